// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit carries out the four single-bit test operations of a processor datapath on a 16-bit or 32-bit operand. One variant only tests the bit. The other three test the bit and then complement, set or clear it. Each request gives the operand value, a bit offset, an operand size, a flag that says whether the operand sits in memory, the operand address, a two-bit operation code and the current flag word. One clock later the unit returns four things: the original value of the chosen bit as the new carry flag, the modified operand, a write enable for writing it back, and the updated flag word.

For a memory operand, the offset may reach past the addressed word. The unit turns the upper offset bits into a signed word displacement and adds it, scaled to bytes, to the address. The caller then fetches the word at the adjusted address and writes it back there. A register operand keeps its address unchanged. A 64-bit size, or the unused size code, is refused: the unit raises an error and writes nothing.

Top module: `bit_test_unit`

## Requirements
- R1: While reset is high, and in the cycle after it falls with no request, `out_valid`, `write_en` and `size_err` are low.
- R2: A request taken while `in_valid` is high produces its results in the next cycle, with `out_valid` high for exactly that one cycle. With no request, `out_valid` is low.
- R3: The bit index is `bit_offset` masked to its low 5 bits for size code 1 (32-bit) and to its low 4 bits for size code 0 (16-bit).
- R4: `carry` is the value the selected bit had before any change.
- R5: Operation code 0 (test) leaves `write_en` low and returns `result` equal to the operand.
- R6: Operation codes 1 (complement), 2 (set) and 3 (clear) raise `write_en` and return the operand with only the selected bit flipped, forced to 1 or forced to 0, respectively.
- R7: For a 32-bit memory operand, `addr_out` is `mem_addr` plus 4 times the signed quotient of `bit_offset`, with its low 5 bits cleared, divided by 32.
- R8: For a 16-bit memory operand, `addr_out` is `mem_addr` plus 2 times the signed quotient of the low 16 bits of `bit_offset`, with their low 4 bits cleared, divided by 16. Offset bits above bit 15 have no effect.
- R9: For a register operand (`from_mem` low), `addr_out` equals `mem_addr`.
- R10: On a valid result, `flags_out` equals `flags_in` in every bit except bit 0 (carry), which takes the value of `carry`.
- R11: Size codes 2 (64-bit) and 3 raise `size_err` and keep `write_en` low. In this case `result` equals the operand, `addr_out` equals `mem_addr`, and `flags_out` equals `flags_in` in every bit, bit 0 included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_code | input | 2 | 0 test, 1 complement, 2 set, 3 clear |
| op_size | input | 2 | 0 16-bit, 1 32-bit, 2 64-bit (error), 3 reserved (error) |
| from_mem | input | 1 | Operand is in memory |
| operand | input | DATA_W | Operand value |
| bit_offset | input | DATA_W | Bit offset, signed for memory operands |
| mem_addr | input | ADDR_W | Operand byte address |
| flags_in | input | FLAG_W | Current flag word, carry at bit 0 |
| out_valid | output | 1 | Result strobe |
| carry | output | 1 | Original value of the selected bit |
| result | output | DATA_W | Modified operand |
| write_en | output | 1 | Write the result back |
| addr_out | output | ADDR_W | Adjusted byte address |
| flags_out | output | FLAG_W | Updated flag word |
| size_err | output | 1 | Unsupported operand size |

## Verification
The bench builds the unit with its defaults: a 32-bit datapath, 32-bit addresses and an 8-bit flag word. With these values the 5-bit and 4-bit index masks and the word and half-word displacement scales are the ones the requirements state. The full signed offset range is also within reach, so negative offsets, offsets at the word edge and 16-bit offsets carrying upper bits can all be driven directly. Random requests mix every operation code, size code and operand location, and directed cases hit the displacement sign changes.

// File: rtl/btm_pkg.sv
package btm_pkg;

    typedef enum logic [1:0] {
        BT_TEST  = 2'd0,
        BT_FLIP  = 2'd1,
        BT_SET   = 2'd2,
        BT_CLEAR = 2'd3
    } bt_op_e;

    typedef enum logic [1:0] {
        SZ_W16  = 2'd0,
        SZ_W32  = 2'd1,
        SZ_W64  = 2'd2,
        SZ_RSVD = 2'd3
    } bt_size_e;

    localparam int CARRY_POS = 0;

    function automatic logic size_supported(input bt_size_e sz);
        return (sz == SZ_W16) || (sz == SZ_W32);
    endfunction

    function automatic logic op_writes(input bt_op_e op);
        return op != BT_TEST;
    endfunction

    function automatic logic new_bit(input bt_op_e op, input logic old);
        case (op)
            BT_FLIP:  return ~old;
            BT_SET:   return 1'b1;
            BT_CLEAR: return 1'b0;
            default:  return old;
        endcase
    endfunction

endpackage

// File: rtl/btm_locate.sv
module btm_locate
    import btm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  bt_size_e                      size,
    input  logic                          from_mem,
    input  logic [DATA_W-1:0]             bit_offset,
    input  logic [ADDR_W-1:0]             mem_addr,
    output logic [$clog2(DATA_W)-1:0]     bit_idx,
    output logic [ADDR_W-1:0]             addr_adj,
    output logic                          bad_size
);
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int HALF_W  = DATA_W / 2;
    localparam int HIDX_W  = IDX_W - 1;
    localparam int SH_FULL = $clog2(DATA_W / 8);
    localparam int SH_HALF = $clog2(HALF_W / 8);
    localparam int HQ_W    = HALF_W - HIDX_W;

    logic signed [DATA_W-1:0] quot_full;
    logic signed [HQ_W-1:0]   quot_half_raw;
    logic signed [ADDR_W-1:0] bytes_full;
    logic signed [ADDR_W-1:0] bytes_half;
    logic signed [ADDR_W-1:0] bytes_sel;

    always_comb begin
        quot_full     = $signed(bit_offset) >>> IDX_W;
        quot_half_raw = $signed(bit_offset[HALF_W-1:HIDX_W]);
        bytes_full    = ADDR_W'(quot_full) <<< SH_FULL;
        bytes_half    = ADDR_W'(quot_half_raw) <<< SH_HALF;
        bad_size      = !size_supported(size);

        if (size == SZ_W32) begin
            bit_idx   = bit_offset[IDX_W-1:0];
            bytes_sel = bytes_full;
        end else begin
            bit_idx   = {1'b0, bit_offset[HIDX_W-1:0]};
            bytes_sel = bytes_half;
        end

        if (from_mem && !bad_size) begin
            addr_adj = mem_addr + ADDR_W'(bytes_sel);
        end else begin
            addr_adj = mem_addr;
        end
    end

endmodule

// File: rtl/btm_modify.sv
module btm_modify
    import btm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  bt_op_e                        op,
    input  logic [DATA_W-1:0]             value,
    input  logic [$clog2(DATA_W)-1:0]     bit_idx,
    input  logic                          bad_size,
    output logic                          old_bit,
    output logic [DATA_W-1:0]             new_value,
    output logic                          wr
);
    logic [DATA_W-1:0] changed;

    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            assign changed[b] = (bit_idx == b) ? new_bit(op, value[b]) : value[b];
        end
    endgenerate

    always_comb begin
        old_bit   = value[bit_idx];
        wr        = op_writes(op) && !bad_size;
        new_value = bad_size ? value : changed;
    end

endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
    import btm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op_code,
    input  logic [1:0]        op_size,
    input  logic              from_mem,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] bit_offset,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              out_valid,
    output logic              carry,
    output logic [DATA_W-1:0] result,
    output logic              write_en,
    output logic [ADDR_W-1:0] addr_out,
    output logic [FLAG_W-1:0] flags_out,
    output logic              size_err
);
    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        logic              carry;
        logic [DATA_W-1:0] value;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [FLAG_W-1:0] flags;
        logic              err;
    } resp_t;

    bt_op_e            op_e;
    bt_size_e          size_e;
    logic [IDX_W-1:0]  bit_idx;
    logic [ADDR_W-1:0] addr_adj;
    logic              bad_size;
    logic              old_bit;
    logic [DATA_W-1:0] new_value;
    logic              wr;
    resp_t             resp_d;
    resp_t             resp_q;
    logic              valid_q;

    assign op_e   = bt_op_e'(op_code);
    assign size_e = bt_size_e'(op_size);

    btm_locate #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_locate (
        .size       (size_e),
        .from_mem   (from_mem),
        .bit_offset (bit_offset),
        .mem_addr   (mem_addr),
        .bit_idx    (bit_idx),
        .addr_adj   (addr_adj),
        .bad_size   (bad_size)
    );

    btm_modify #(.DATA_W(DATA_W)) u_modify (
        .op        (op_e),
        .value     (operand),
        .bit_idx   (bit_idx),
        .bad_size  (bad_size),
        .old_bit   (old_bit),
        .new_value (new_value),
        .wr        (wr)
    );

    always_comb begin
        resp_d.carry = bad_size ? flags_in[CARRY_POS] : old_bit;
        resp_d.value = new_value;
        resp_d.wr    = wr;
        resp_d.addr  = addr_adj;
        resp_d.err   = bad_size;
        resp_d.flags = flags_in;
        if (!bad_size) begin
            resp_d.flags[CARRY_POS] = old_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            resp_q  <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                resp_q <= resp_d;
            end else begin
                resp_q.wr  <= 1'b0;
                resp_q.err <= 1'b0;
            end
        end
    end

    assign out_valid = valid_q;
    assign carry     = resp_q.carry;
    assign result    = resp_q.value;
    assign write_en  = resp_q.wr;
    assign addr_out  = resp_q.addr;
    assign flags_out = resp_q.flags;
    assign size_err  = resp_q.err;

endmodule

// File: rtl/btm_checker.sv
module btm_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int FLAG_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        op_code,
    input logic [1:0]        op_size,
    input logic              from_mem,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] bit_offset,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [FLAG_W-1:0] flags_in,
    input logic              out_valid,
    input logic              carry,
    input logic [DATA_W-1:0] result,
    input logic              write_en,
    input logic [ADDR_W-1:0] addr_out,
    input logic [FLAG_W-1:0] flags_out,
    input logic              size_err
);
    localparam logic [FLAG_W-1:0] REST_MASK = ~FLAG_W'(1);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !write_en && !size_err));

    p_one_cycle_latency_r2: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid) |-> out_valid);

    p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> !out_valid);

    p_carry_original_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && $past(op_size) == 2'd1)
            |-> carry == $past(operand[bit_offset[4:0]]));

    p_test_no_write_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && $past(op_code) == 2'd0) |-> !write_en);

    p_modify_writes_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && $past(op_code) != 2'd0 && !$past(op_size[1]))
            |-> write_en);

    p_register_no_adjust_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && !$past(from_mem)) |-> addr_out == $past(mem_addr));

    p_other_flags_kept_r10: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid) |-> (flags_out & REST_MASK) == ($past(flags_in) & REST_MASK));

    p_error_no_write_r11: assert property (@(posedge clk) disable iff (rst)
        size_err |-> (!write_en && out_valid));

    p_wide_size_flags_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && $past(op_size[1])) |-> (size_err && flags_out == $past(flags_in)));

endmodule

bind bit_test_unit btm_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_btm_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code), .op_size(op_size),
    .from_mem(from_mem), .operand(operand), .bit_offset(bit_offset), .mem_addr(mem_addr),
    .flags_in(flags_in), .out_valid(out_valid), .carry(carry), .result(result),
    .write_en(write_en), .addr_out(addr_out), .flags_out(flags_out), .size_err(size_err)
);

// File: tb/test_bit_test_unit.sv
`timescale 1ns/1ps
module test_bit_test_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op_code = '0;
    logic [1:0]  op_size = '0;
    logic        from_mem = 1'b0;
    logic [31:0] operand = '0;
    logic [31:0] bit_offset = '0;
    logic [31:0] mem_addr = '0;
    logic [7:0]  flags_in = '0;
    logic        out_valid;
    logic        carry;
    logic [31:0] result;
    logic        write_en;
    logic [31:0] addr_out;
    logic [7:0]  flags_out;
    logic        size_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bit_test_unit i_bit_test_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code), .op_size(op_size),
        .from_mem(from_mem), .operand(operand), .bit_offset(bit_offset), .mem_addr(mem_addr),
        .flags_in(flags_in), .out_valid(out_valid), .carry(carry), .result(result),
        .write_en(write_en), .addr_out(addr_out), .flags_out(flags_out), .size_err(size_err)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int exp_index(input logic [1:0] sz, input logic [31:0] off);
        return (sz == 2'd1) ? int'(off & 32'h1f) : int'(off & 32'hf);
    endfunction

    function automatic logic [31:0] exp_addr(input logic [1:0] sz, input logic mem,
                                             input logic [31:0] off, input logic [31:0] a);
        int q;
        if (!mem || sz[1]) return a;
        if (sz == 2'd1) begin
            q = int'($signed(off & 32'hffffffe0)) / 32;
            return a + 32'(4 * q);
        end
        q = int'($signed(off[15:0] & 16'hfff0)) / 16;
        return a + 32'(2 * q);
    endfunction

    function automatic logic [31:0] exp_result(input logic [1:0] op, input logic [1:0] sz,
                                               input logic [31:0] v, input int idx);
        logic [31:0] m;
        m = 32'd1 << idx;
        if (sz[1]) return v;
        case (op)
            2'd1:    return v ^ m;
            2'd2:    return v | m;
            2'd3:    return v & ~m;
            default: return v;
        endcase
    endfunction

    task automatic run_one(input logic [1:0] op, input logic [1:0] sz, input logic mem,
                           input logic [31:0] v, input logic [31:0] off,
                           input logic [31:0] a, input logic [7:0] fl, input string tag);
        int idx;
        logic bad;
        logic expc;
        logic [7:0] expf;
        @(negedge clk);
        op_code = op; op_size = sz; from_mem = mem; operand = v;
        bit_offset = off; mem_addr = a; flags_in = fl; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        idx  = exp_index(sz, off);
        bad  = sz[1];
        expc = bad ? fl[0] : v[idx];
        expf = bad ? fl : {fl[7:1], expc};
        check({"R2 ", tag}, "out_valid", 32'(out_valid), 32'd1);
        check({"R4 ", tag}, "carry", 32'(carry), 32'(expc));
        check({"R6 ", tag}, "result", result, exp_result(op, sz, v, idx));
        check({"R5 ", tag}, "write_en", 32'(write_en), 32'(!bad && op != 2'd0));
        check({"R7 ", tag}, "addr_out", addr_out, exp_addr(sz, mem, off, a));
        check({"R10 ", tag}, "flags_out", 32'(flags_out), 32'(expf));
        check({"R11 ", tag}, "size_err", 32'(size_err), 32'(bad));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
        check("R1", "write_en in reset", 32'(write_en), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
        check("R1", "size_err after reset", 32'(size_err), 32'd0);

        // R3: index masking at word edge, R5 test op
        run_one(2'd0, 2'd1, 1'b0, 32'h8000_0000, 32'h0000_003f, 32'h100, 8'h00, "r3_bit31");
        run_one(2'd1, 2'd0, 1'b0, 32'h0000_8000, 32'h0000_001f, 32'h100, 8'hff, "r3_bit15");
        // R7: 32-bit memory displacement
        run_one(2'd2, 2'd1, 1'b1, 32'h0, 32'h0000_0020, 32'h1000, 8'h5a, "r7_plus1");
        run_one(2'd3, 2'd1, 1'b1, 32'hffff_ffff, 32'hffff_ffff, 32'h1000, 8'ha5, "r7_minus1");
        run_one(2'd1, 2'd1, 1'b1, 32'h1234_5678, 32'h8000_0000, 32'h0, 8'h01, "r7_min");
        // R8: 16-bit memory displacement, upper offset bits ignored
        run_one(2'd2, 2'd0, 1'b1, 32'h0, 32'h0000_ffff, 32'h2000, 8'h00, "r8_minus1");
        run_one(2'd3, 2'd0, 1'b1, 32'hffff, 32'h1234_0015, 32'h2000, 8'h00, "r8_upper");
        run_one(2'd0, 2'd0, 1'b1, 32'h0, 32'h0000_8000, 32'h2000, 8'h00, "r8_min");
        // R9: register operand, large offset
        run_one(2'd2, 2'd1, 1'b0, 32'h0, 32'h7fff_ffe3, 32'h3000, 8'h00, "r9_reg");
        // R11: wide and reserved sizes
        run_one(2'd1, 2'd2, 1'b1, 32'hdead_beef, 32'h0000_0045, 32'h4000, 8'h81, "r11_w64");
        run_one(2'd3, 2'd3, 1'b0, 32'h0f0f_0f0f, 32'h0000_0001, 32'h4000, 8'h7e, "r11_rsvd");

        @(negedge clk);
        check("R2", "out_valid idle", 32'(out_valid), 32'd0);

        for (int n = 0; n < 400; n++) begin
            run_one(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 1'($urandom),
                    $urandom, $urandom, $urandom, 8'($urandom), "random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule